// File: doc/BRIEF.md
# Bus-Mapped Status and Setting Register Bank

This block is a small register bank on a Wishbone-style slave port. It has two kinds of registers. Status registers are read-only, and the surrounding logic drives their values. Setting registers are read/write, hold control values for that logic, and each comes out of reset at its own default value. Each transfer is one single read or write. A two-state machine answers each transfer with a one-cycle acknowledge, or with an error when the address matches no register.

Every setting register has its own one-bit synchronous clear. The clear lets the logic that owns a setting put it back to its default without going through the bus. If a clear and a bus write hit the same register in the same clock, the clear takes effect.

An active-low asynchronous reset loads all setting defaults. A synchronised bus reset output is driven from that reset.

With default parameters the layout is:

- Status register k sits at address 0x00 + k.
- Setting register k sits at address 0x10 + k.
- The default of setting k is 0x5A00 + k.
- There are four registers of each kind, 32 data bits and 8 address bits.

Top module: `wb_regbank`

## Requirements
- R1: While `rst_n_i` is low, every setting register k holds its default 0x5A00 + k, seen on `set_o[32k+31:32k]`.
- R2: `bus_rst_o` is high while `rst_n_i` is low. After `rst_n_i` rises, `bus_rst_o` stays high through exactly two rising clock edges and is low after the second one.
- R3: The state machine moves from IDLE to RESP on an edge where `cyc_i` and `stb_i` are both high, and from RESP back to IDLE on the next edge. A response (`ack_o` or `err_o`) is high only in RESP while `cyc_i` and `stb_i` are both high. It therefore lasts one cycle, and it is never raised while either of them is low.
- R4: A setting register takes `dat_i` only at the edge that ends an acknowledged cycle with `we_i` high and `adr_i` equal to that register's address. No other setting register changes.
- R5: In an acknowledged read of a setting address, `dat_o` equals that register's current value.
- R6: In an acknowledged read of a status address, `dat_o` equals the value on that status input during the acknowledge cycle, even if the input changed since the previous cycle.
- R7: When `set_clr_i[k]` is high at a rising edge, setting k returns to its default at that edge.
- R8: When a clear and an acknowledged write to the same setting meet at one edge, the register ends at its default.
- R9: A request to an address that matches no register gets `err_o` in place of `ack_o`, changes no setting, and returns `dat_o` = 0.
- R10: `rty_o` is always low.
- R11: If `stb_i` falls while the machine is in RESP, no response is given and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| bus_rst_o | output | 1 | Synchronised active-high bus reset |
| cyc_i | input | 1 | Cycle valid from the master |
| stb_i | input | 1 | Strobe from the master |
| we_i | input | 1 | Write enable (1 = write) |
| adr_i | input | AW (8) | Register address |
| dat_i | input | DW (32) | Write data |
| dat_o | output | DW (32) | Read data, valid with `ack_o` |
| ack_o | output | 1 | Acknowledge of a mapped access |
| err_o | output | 1 | Error response for an unmapped address |
| rty_o | output | 1 | Retry response, tied low |
| status_i | input | N_STAT*DW (128) | Status inputs, register k at bits [DW*k +: DW] |
| set_o | output | N_SET*DW (128) | Setting values, register k at bits [DW*k +: DW] |
| set_clr_i | input | N_SET (4) | Per-setting synchronous clear to default |

## Verification
The assertions check the following on every cycle:
- The response only ever appears while the request is present, and never for two cycles in a row.
- `ack_o` and `err_o` are never high together.
- A setting holds its value unless an acknowledged write or its clear is present.
- A clear always leaves its register at the default, even when a write lands at the same edge.

The bench scenarios cover the rest:
- Data correctness of reads against a reference model of the settings.
- A status input that changes in the acknowledge cycle itself.
- The bus reset release timing.
- The abort case.
- Proof that an error-terminated write leaves every register untouched.

// File: rtl/wbrf_pkg.sv
package wbrf_pkg;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } wbrf_state_e;

    // Address table entries, computed from bases and the register index
    function automatic int unsigned stat_addr(int unsigned base, int unsigned k);
        return base + k;
    endfunction

    function automatic int unsigned set_addr(int unsigned base, int unsigned k);
        return base + k;
    endfunction

    // Default value of setting k
    function automatic int unsigned set_default(int unsigned k);
        return 32'h0000_5A00 + k;
    endfunction

endpackage

// File: rtl/wbrf_rst_sync.sv
module wbrf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic bus_rst_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign bus_rst_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/wbrf_decode.sv
module wbrf_decode #(
    parameter int          N_STAT    = 4,
    parameter int          N_SET     = 4,
    parameter int          AW        = 8,
    parameter int unsigned STAT_BASE = 0,
    parameter int unsigned SET_BASE  = 16
) (
    input  logic [AW-1:0]     adr_i,
    output logic [N_STAT-1:0] stat_hit_o,
    output logic [N_SET-1:0]  set_hit_o,
    output logic              any_hit_o
);
    import wbrf_pkg::*;

    for (genvar k = 0; k < N_STAT; k++) begin : g_stat
        localparam logic [AW-1:0] ADDR = AW'(stat_addr(STAT_BASE, k));
        assign stat_hit_o[k] = (adr_i == ADDR);
    end

    for (genvar k = 0; k < N_SET; k++) begin : g_set
        localparam logic [AW-1:0] ADDR = AW'(set_addr(SET_BASE, k));
        assign set_hit_o[k] = (adr_i == ADDR);
    end

    assign any_hit_o = (|stat_hit_o) | (|set_hit_o);

endmodule

// File: rtl/wbrf_settings.sv
module wbrf_settings #(
    parameter int N_SET = 4,
    parameter int DW    = 32
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic                wr_stb_i,
    input  logic [N_SET-1:0]    hit_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic [N_SET-1:0]    clr_i,
    output logic [N_SET*DW-1:0] val_o
);
    import wbrf_pkg::*;

    for (genvar k = 0; k < N_SET; k++) begin : g_reg
        localparam logic [DW-1:0] DEF = DW'(set_default(k));
        logic [DW-1:0] q;

        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
                q <= DEF;
            end else if (clr_i[k]) begin
                q <= DEF;                   // clear beats bus write
            end else if (wr_stb_i && hit_i[k]) begin
                q <= wdata_i;
            end
        end

        assign val_o[k*DW +: DW] = q;
    end

endmodule

// File: rtl/wb_regbank.sv
module wb_regbank #(
    parameter int          N_STAT     = 4,
    parameter int          N_SET      = 4,
    parameter int          DW         = 32,
    parameter int          AW         = 8,
    parameter int unsigned STAT_BASE  = 0,
    parameter int unsigned SET_BASE   = 16,
    parameter int          RST_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    output logic                 bus_rst_o,
    input  logic                 cyc_i,
    input  logic                 stb_i,
    input  logic                 we_i,
    input  logic [AW-1:0]        adr_i,
    input  logic [DW-1:0]        dat_i,
    output logic [DW-1:0]        dat_o,
    output logic                 ack_o,
    output logic                 err_o,
    output logic                 rty_o,
    input  logic [N_STAT*DW-1:0] status_i,
    output logic [N_SET*DW-1:0]  set_o,
    input  logic [N_SET-1:0]     set_clr_i
);
    import wbrf_pkg::*;

    wbrf_state_e       state_q, state_d;
    logic [N_STAT-1:0] stat_hit;
    logic [N_SET-1:0]  set_hit;
    logic              any_hit;
    logic              resp_v;
    logic              wr_stb;
    logic [DW-1:0]     rd_mux;

    wbrf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .bus_rst_o (bus_rst_o)
    );

    wbrf_decode #(
        .N_STAT    (N_STAT),
        .N_SET     (N_SET),
        .AW        (AW),
        .STAT_BASE (STAT_BASE),
        .SET_BASE  (SET_BASE)
    ) u_dec (
        .adr_i      (adr_i),
        .stat_hit_o (stat_hit),
        .set_hit_o  (set_hit),
        .any_hit_o  (any_hit)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (cyc_i && stb_i) state_d = S_RESP;
            S_RESP: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        resp_v = (state_q == S_RESP) && cyc_i && stb_i;
        ack_o  = resp_v && any_hit;
        err_o  = resp_v && !any_hit;
        rty_o  = 1'b0;
        wr_stb = ack_o && we_i;
    end

    // Read multiplexer: one-hot OR over all mapped registers
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < N_STAT; k++) begin
            if (stat_hit[k]) rd_mux = rd_mux | status_i[k*DW +: DW];
        end
        for (int k = 0; k < N_SET; k++) begin
            if (set_hit[k]) rd_mux = rd_mux | set_o[k*DW +: DW];
        end
    end

    assign dat_o = ack_o ? rd_mux : '0;

    wbrf_settings #(.N_SET(N_SET), .DW(DW)) u_set (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .wr_stb_i (wr_stb),
        .hit_i    (set_hit),
        .wdata_i  (dat_i),
        .clr_i    (set_clr_i),
        .val_o    (set_o)
    );

endmodule

// File: rtl/wb_regbank_chk.sv
module wb_regbank_chk #(
    parameter int N_SET = 4,
    parameter int DW    = 32
) (
    input logic                clk_i,
    input logic                rst_n_i,
    input logic                cyc_i,
    input logic                stb_i,
    input logic                we_i,
    input logic                ack_o,
    input logic                err_o,
    input logic [N_SET*DW-1:0] set_o,
    input logic [N_SET-1:0]    set_clr_i
);
    import wbrf_pkg::*;

    a_r3_resp_needs_req: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ack_o || err_o) |-> (cyc_i && stb_i));

    a_r3_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ack_o || err_o) |=> !(ack_o || err_o));

    a_r9_ack_err_excl: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(ack_o && err_o));

    for (genvar k = 0; k < N_SET; k++) begin : g_chk
        localparam logic [DW-1:0] DEF = DW'(set_default(k));

        // R7 and R8: a clear always lands at the default
        a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            set_clr_i[k] |=> (set_o[k*DW +: DW] == DEF));

        a_r4_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (!(ack_o && we_i) && !set_clr_i[k]) |=> $stable(set_o[k*DW +: DW]));
    end

endmodule

bind wb_regbank wb_regbank_chk #(.N_SET(N_SET), .DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .cyc_i     (cyc_i),
    .stb_i     (stb_i),
    .we_i      (we_i),
    .ack_o     (ack_o),
    .err_o     (err_o),
    .set_o     (set_o),
    .set_clr_i (set_clr_i)
);

// File: tb/wb_regbank_bench.sv
module wb_regbank_bench;

    localparam int NS = 4, NT = 4, DW = 32, AW = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n;
    logic            bus_rst, cyc, stb, we, ack, err, rty;
    logic [AW-1:0]   adr;
    logic [DW-1:0]   wdat, rdat;
    logic [NS*DW-1:0] status;
    logic [NT*DW-1:0] setv;
    logic [NT-1:0]   clr;

    wb_regbank u_wb_regbank (
        .clk_i(clk), .rst_n_i(rst_n), .bus_rst_o(bus_rst),
        .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr), .dat_i(wdat),
        .dat_o(rdat), .ack_o(ack), .err_o(err), .rty_o(rty),
        .status_i(status), .set_o(setv), .set_clr_i(clr)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DW-1:0] model [NT];

    function automatic logic [DW-1:0] dflt(int k);
        return 32'h5A00 + k;
    endfunction

    function automatic bit is_stat(logic [AW-1:0] a);
        return a < 8'h04;
    endfunction

    function automatic bit is_set(logic [AW-1:0] a);
        return a >= 8'h10 && a < 8'h14;
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_settings(string req);
        for (int k = 0; k < NT; k++) chk(req, setv[k*DW +: DW], model[k]);
    endtask

    // One transfer.
    // Drive at a negedge; sample in the RESP cycle; optional clear meets the commit edge.
    task automatic xfer(bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [NT-1:0] c,
                        bit change_stat);
        bit mapped = is_stat(a) || is_set(a);
        logic [DW-1:0] exp_rd;
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; wdat = d;
        @(posedge clk);
        @(negedge clk);
        if (change_stat) status = {$urandom, $urandom, $urandom, $urandom};
        clr = c;
        #0.5;
        chk("R3 ack", {31'd0, ack}, {31'd0, mapped});
        chk("R9 err", {31'd0, err}, {31'd0, !mapped});
        chk("R10 rty", {31'd0, rty}, 32'd0);
        if (!w) begin
            if (is_stat(a))     exp_rd = status[a*DW +: DW];
            else if (is_set(a)) exp_rd = model[a - 8'h10];
            else                exp_rd = '0;
            chk(is_stat(a) ? "R6 status read" : (is_set(a) ? "R5 setting read" : "R9 err data"),
                rdat, exp_rd);
        end
        @(posedge clk);
        if (w && is_set(a)) model[a - 8'h10] = d;
        for (int k = 0; k < NT; k++) if (c[k]) model[k] = dflt(k);   // R8 clear wins
        @(negedge clk);
        cyc = 0; stb = 0; clr = '0;
        #0.5;
        chk("R3 one cycle", {31'd0, ack | err}, 32'd0);
        chk_settings(w ? "R4 write" : "R4 no write on read");
    endtask

    initial begin
        int cyc_cnt = 0;
        forever begin
            @(posedge clk);
            cyc_cnt++;
            if (cyc_cnt > 100000 && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected finish");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 0; cyc = 0; stb = 0; we = 0; adr = '0; wdat = '0; clr = '0;
        status = {32'h1111_0003, 32'h1111_0002, 32'h1111_0001, 32'h1111_0000};
        for (int k = 0; k < NT; k++) model[k] = dflt(k);

        repeat (3) @(negedge clk);
        chk("R2 bus reset held", {31'd0, bus_rst}, 32'd1);
        chk_settings("R1 defaults");

        rst_n = 1;                       // released at a negedge
        @(negedge clk);
        chk("R2 high after edge 1", {31'd0, bus_rst}, 32'd1);
        @(negedge clk);
        chk("R2 low after edge 2", {31'd0, bus_rst}, 32'd0);

        // R3: no response while only one of cyc/stb is high
        cyc = 1; stb = 0; adr = 8'h10;
        repeat (3) begin
            @(negedge clk);
            chk("R3 cyc only", {31'd0, ack | err}, 32'd0);
        end
        cyc = 0; stb = 1;
        repeat (3) begin
            @(negedge clk);
            chk("R3 stb only", {31'd0, ack | err}, 32'd0);
        end
        stb = 0;

        // Directed transfers
        xfer(1, 8'h12, 32'hCAFE_0012, '0, 0);
        xfer(0, 8'h12, 0, '0, 0);
        xfer(0, 8'h02, 0, '0, 1);               // R6 status changed in ack cycle
        xfer(1, 8'h55, 32'hDEAD_BEEF, '0, 0);   // R9 unmapped write
        xfer(0, 8'hFF, 0, '0, 0);               // R9 unmapped read
        xfer(1, 8'h11, 32'h0BAD_F00D, 4'b0010, 0);  // R8 clear beats write
        xfer(0, 8'h11, 0, '0, 0);

        // R7: clear while idle
        @(negedge clk);
        clr = 4'b0100; model[2] = dflt(2);
        @(negedge clk);
        clr = '0;
        chk_settings("R7 idle clear");

        // R11: strobe drops in RESP, write dropped
        @(negedge clk);
        cyc = 1; stb = 1; we = 1; adr = 8'h13; wdat = 32'h7777_7777;
        @(negedge clk);
        stb = 0;
        #0.5;
        chk("R11 abort no ack", {31'd0, ack | err}, 32'd0);
        @(negedge clk);
        cyc = 0;
        chk_settings("R11 abort no write");

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            int sel = $urandom_range(0, 9);
            logic [AW-1:0] a;
            logic [NT-1:0] c;
            if (sel < 4)      a = 8'h10 + AW'($urandom_range(0, 3));
            else if (sel < 8) a = AW'($urandom_range(0, 3));
            else              a = 8'h20 + AW'($urandom_range(0, 200));
            c = ($urandom_range(0, 7) == 0) ? NT'($urandom) : '0;
            xfer($urandom_range(0, 1) == 1, a, $urandom, c, $urandom_range(0, 1) == 1);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule